// File: doc/BRIEF.md
# TDM Slot Serializer with AUX Extraction

This block drives and receives one time-division-multiplexed audio stream. Each frame is cut into 32-bit slots and starts at a one-cycle frame-sync pulse. The block runs on the TDM bit clock, so one `clk` cycle carries one TDM bit. A parallel buffer of outgoing channel words is shifted out slot by slot. The incoming serial line is cut back into one word per slot, and those words are presented on a parallel bus. A frame holds 4, 8 or 16 slots.

In AUX mode the frame holds 16 slots. The words received in the last four slots are copied into a holding register when the frame ends. During the following frame they are replayed on two slow stereo data lines. The stereo port has its own bit clock and left/right clock, both derived from the TDM bit count. Its frame holds 64 of its own bits, so it runs 8 times slower than the TDM line. A request for AUX mode together with a frame too short to spare four slots is refused. In that case the frame runs as plain single-line TDM and an error flag is raised.

Top module: `tdm_aux_core`

## Requirements
- R1: The cycle in which `fsync` is high is the last cycle before the frame. Bit k of the frame is on the line k+1 cycles later. `slot_cfg` 0, 1 and 2 select 4, 8 and 16 slots of 32 bits, that is 128, 256 or 512 cycles. The position counter wraps at the frame end by itself.
- R2: Outgoing slot s carries the word at `tx_data[s*W +: W]`, starting with slot 0. Each word is sent MSB first in the first W bits of its slot, and the remaining 32-W bits are zero.
- R3: Only slots 0 to TX_ACTIVE-1 (default 4) carry data. All other slots of the frame are driven 0.
- R4: `rx_frame_done` rises in the first cycle after the last bit of a frame. At that point, for each slot s of that frame, `rx_data[s*W +: W]` holds the first W bits received in slot s, MSB first. The padding bits of the slot are ignored.
- R5: `slot_cfg` and `aux_req` are sampled only in the `fsync` cycle. Changing them in the middle of a frame changes neither the outputs nor `cfg_err`.
- R6: With `slot_cfg`=2 and `aux_req`=1, the words of slots 12 to 15 are held when the frame ends and sent during the next frame. `aux_sdo[0]` carries slot 12 (left) and slot 13 (right). `aux_sdo[1]` carries slot 14 (left) and slot 15 (right).
- R7: Each AUX bit lasts 8 cycles. `aux_bclk` is low for 4 cycles and then high for 4, and data changes only where `aux_bclk` falls. `aux_lrclk` is 0 for the 32 left bits and 1 for the 32 right bits. Each word is sent MSB first, followed by zeros.
- R8: `aux_bclk`, `aux_lrclk` and `aux_sdo` stay 0 outside AUX mode. They also stay 0 during the first AUX frame, because nothing has been held yet.
- R9: The flag `cfg_err` is set for the frame when `aux_req`=1 is given with `slot_cfg` 0 or 1, or when `slot_cfg`=3 is given. That frame runs as single-line TDM (code 3 as 8 slots) and the AUX outputs stay 0.
- R10: After reset every output is 0. The outputs stay 0 until the first `fsync`.
- R11: `rx_frame_done` is high for exactly one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TDM bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync, high in the last cycle before a frame |
| slot_cfg | input | 2 | Frame length: 0=4, 1=8, 2=16 slots, 3=rejected |
| aux_req | input | 1 | Request AUX extraction mode |
| tx_data | input | 16*W | Outgoing channel words, slot s at bits s*W |
| tdm_sdo | output | 1 | Serial TDM data out |
| tdm_sdi | input | 1 | Serial TDM data in |
| rx_data | output | 16*W | Received channel words, slot s at bits s*W |
| rx_frame_done | output | 1 | One-cycle pulse after a frame is fully received |
| aux_bclk | output | 1 | AUX bit clock |
| aux_lrclk | output | 1 | AUX left/right clock |
| aux_sdo | output | 2 | AUX stereo data lines |
| cfg_err | output | 1 | Rejected configuration in the current frame |

## Verification
Frames of all three lengths are run with words computed from a seed, and with the all-ones and 0x800001 patterns. These patterns separate the data bits from the zero padding, and they catch an MSB/LSB swap at bit W-1 against bit W. AUX runs of several frames in a row show the one-frame delay and the silent first frame. The bench also enters and leaves AUX mode, and it tries the rejected requests with 4-slot, 8-slot and reserved frame codes. In every frame the configuration inputs are changed in the middle of the frame, which shows that only the value sampled at `fsync` counts.

// File: rtl/tdm_aux_pkg.sv
package tdm_aux_pkg;

    localparam int TDM_NSLOT_MAX = 16;

    typedef enum logic [1:0] {
        FRM_4   = 2'd0,
        FRM_8   = 2'd1,
        FRM_16  = 2'd2,
        FRM_RSV = 2'd3
    } frm_e;

    function automatic int tdm_nslots(frm_e f);
        case (f)
            FRM_4:   return 4;
            FRM_16:  return 16;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
    import tdm_aux_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int POS_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [1:0]       slot_cfg,
    input  logic             aux_req,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_d,
    output logic             locked_q,
    output logic             locked_d,
    output frm_e             len_q,
    output frm_e             len_d,
    output logic             aux_q,
    output logic             aux_d,
    output logic             err_q,
    output logic             frame_last
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             locked;
        frm_e             len;
        logic             aux;
        logic             err;
    } ctl_t;

    ctl_t s_q, s_d;

    function automatic logic [POS_W-1:0] last_pos(frm_e f);
        return POS_W'(tdm_nslots(f) * SLOT_BITS - 1);
    endfunction

    always_comb begin
        s_d        = s_q;
        frame_last = s_q.locked && (s_q.pos == last_pos(s_q.len));
        if (fsync) begin
            s_d.locked = 1'b1;
            s_d.pos    = '0;
            s_d.aux    = aux_req && (slot_cfg == 2'd2);
            s_d.err    = (slot_cfg == 2'd3) || (aux_req && (slot_cfg != 2'd2));
            case (slot_cfg)
                2'd0:    s_d.len = FRM_4;
                2'd2:    s_d.len = FRM_16;
                default: s_d.len = FRM_8;
            endcase
        end else if (s_q.locked) begin
            s_d.pos = frame_last ? '0 : s_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pos: '0, locked: 1'b0, len: FRM_8, aux: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_q    = s_q.pos;
    assign pos_d    = s_d.pos;
    assign locked_q = s_q.locked;
    assign locked_d = s_d.locked;
    assign len_q    = s_q.len;
    assign len_d    = s_d.len;
    assign aux_q    = s_q.aux;
    assign aux_d    = s_d.aux;
    assign err_q    = s_q.err;

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
    import tdm_aux_pkg::*;
#(
    parameter int W         = 24,
    parameter int SLOT_BITS = 32,
    parameter int NSLOT     = 16,
    parameter int TX_ACTIVE = 4,
    parameter int POS_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT*W-1:0] tx_words,
    input  logic [POS_W-1:0] pos_d,
    input  logic             locked_d,
    input  frm_e             len_d,
    output logic             sdo_q
);

    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam int IDX_W = $clog2(NSLOT * W);

    logic             sdo_d;
    logic [IDX_W-1:0] idx;
    int               slot_i;
    int               bit_i;

    always_comb begin
        slot_i = int'(pos_d[POS_W-1:BIT_W]);
        bit_i  = int'(pos_d[BIT_W-1:0]);
        idx    = '0;
        sdo_d  = 1'b0;
        if (locked_d && (slot_i < tdm_nslots(len_d)) && (slot_i < TX_ACTIVE) && (bit_i < W)) begin
            idx   = IDX_W'(slot_i * W + (W - 1 - bit_i));
            sdo_d = tx_words[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= sdo_d;
    end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_aux_pkg::*;
#(
    parameter int W         = 24,
    parameter int SLOT_BITS = 32,
    parameter int NSLOT     = 16,
    parameter int POS_W     = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sdi,
    input  logic [POS_W-1:0]   pos_q,
    input  logic               locked_q,
    input  frm_e               len_q,
    input  logic               frame_last,
    output logic [NSLOT*W-1:0] words_q,
    output logic               done_q
);

    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam int IDX_W = $clog2(NSLOT * W);

    typedef struct packed {
        logic [W-2:0]       sh;
        logic [NSLOT*W-1:0] words;
        logic               done;
    } rx_t;

    rx_t              s_q, s_d;
    logic [IDX_W-1:0] widx;
    int               slot_i;
    int               bit_i;

    always_comb begin
        s_d      = s_q;
        slot_i   = int'(pos_q[POS_W-1:BIT_W]);
        bit_i    = int'(pos_q[BIT_W-1:0]);
        widx     = IDX_W'(slot_i * W);
        s_d.done = frame_last;
        if (locked_q && (bit_i < W)) begin
            s_d.sh = {s_q.sh[W-3:0], sdi};
            if ((bit_i == W - 1) && (slot_i < tdm_nslots(len_q))) begin
                s_d.words[widx +: W] = {s_q.sh, sdi};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign words_q = s_q.words;
    assign done_q  = s_q.done;

endmodule

// File: rtl/tdm_aux_ser.sv
module tdm_aux_ser #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4*W-1:0] ext_words,
    input  logic         frame_last,
    input  logic         aux_q,
    input  logic         aux_d,
    input  logic         locked_d,
    input  logic [6:0]   aux_pos,
    output logic         aux_bclk,
    output logic         aux_lrclk,
    output logic [1:0]   aux_sdo
);

    localparam int HIDX_W = $clog2(4 * W);

    typedef struct packed {
        logic [4*W-1:0] hold;
        logic           valid;
        logic           bclk;
        logic           lr;
        logic [1:0]     sdo;
    } aux_t;

    aux_t              s_q, s_d;
    logic [HIDX_W-1:0] hidx;
    int                bit_i;
    int                half_i;

    always_comb begin
        s_d    = s_q;
        hidx   = '0;
        half_i = int'(aux_pos[6]);
        bit_i  = int'(aux_pos[5:1]);
        if (frame_last && aux_q) begin
            s_d.hold  = ext_words;
            s_d.valid = 1'b1;
        end
        if (!aux_d) s_d.valid = 1'b0;
        s_d.bclk = 1'b0;
        s_d.lr   = 1'b0;
        s_d.sdo  = 2'b00;
        if (s_d.valid && locked_d) begin
            s_d.bclk = aux_pos[0];
            s_d.lr   = aux_pos[6];
            for (int k = 0; k < 2; k++) begin
                if (bit_i < W) begin
                    hidx       = HIDX_W'((2 * k + half_i) * W + (W - 1 - bit_i));
                    s_d.sdo[k] = s_d.hold[hidx];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign aux_bclk  = s_q.bclk;
    assign aux_lrclk = s_q.lr;
    assign aux_sdo   = s_q.sdo;

endmodule

// File: rtl/tdm_aux_core.sv
module tdm_aux_core
    import tdm_aux_pkg::*;
#(
    parameter int W         = 24,
    parameter int SLOT_BITS = 32,
    parameter int TX_ACTIVE = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fsync,
    input  logic [1:0]                 slot_cfg,
    input  logic                       aux_req,
    input  logic [TDM_NSLOT_MAX*W-1:0] tx_data,
    output logic                       tdm_sdo,
    input  logic                       tdm_sdi,
    output logic [TDM_NSLOT_MAX*W-1:0] rx_data,
    output logic                       rx_frame_done,
    output logic                       aux_bclk,
    output logic                       aux_lrclk,
    output logic [1:0]                 aux_sdo,
    output logic                       cfg_err
);

    localparam int NSLOT     = TDM_NSLOT_MAX;
    localparam int FRAME_MAX = NSLOT * SLOT_BITS;
    localparam int POS_W     = $clog2(FRAME_MAX);
    localparam int STEP_W    = POS_W - 6;
    localparam int AUX_FIRST = NSLOT - 4;

    logic [POS_W-1:0] pos_q, pos_d;
    logic             locked_q, locked_d;
    frm_e             len_q, len_d;
    logic             aux_q, aux_d;
    logic             frame_last;

    tdm_frame_ctl #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_cfg(slot_cfg), .aux_req(aux_req),
        .pos_q(pos_q), .pos_d(pos_d), .locked_q(locked_q), .locked_d(locked_d),
        .len_q(len_q), .len_d(len_d), .aux_q(aux_q), .aux_d(aux_d),
        .err_q(cfg_err), .frame_last(frame_last)
    );

    tdm_tx_ser #(.W(W), .SLOT_BITS(SLOT_BITS), .NSLOT(NSLOT), .TX_ACTIVE(TX_ACTIVE), .POS_W(POS_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_words(tx_data), .pos_d(pos_d),
        .locked_d(locked_d), .len_d(len_d), .sdo_q(tdm_sdo)
    );

    tdm_rx_deser #(.W(W), .SLOT_BITS(SLOT_BITS), .NSLOT(NSLOT), .POS_W(POS_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sdi(tdm_sdi), .pos_q(pos_q), .locked_q(locked_q),
        .len_q(len_q), .frame_last(frame_last), .words_q(rx_data), .done_q(rx_frame_done)
    );

    tdm_aux_ser #(.W(W)) u_aux (
        .clk(clk), .rst_n(rst_n), .ext_words(rx_data[AUX_FIRST*W +: 4*W]),
        .frame_last(frame_last), .aux_q(aux_q), .aux_d(aux_d), .locked_d(locked_d),
        .aux_pos(pos_d[POS_W-1:STEP_W-1]),
        .aux_bclk(aux_bclk), .aux_lrclk(aux_lrclk), .aux_sdo(aux_sdo)
    );

endmodule

// File: rtl/tdm_aux_sva.sv
module tdm_aux_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       fsync,
    input logic       cfg_err,
    input logic       rx_frame_done,
    input logic       aux_bclk,
    input logic       aux_lrclk,
    input logic [1:0] aux_sdo
);

    p_err_mutes_aux_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!aux_bclk && !aux_lrclk && (aux_sdo == 2'b00)));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_done |=> !rx_frame_done);

    p_err_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fsync) |-> $stable(cfg_err));

    p_lr_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(aux_lrclk) |-> $fell(aux_bclk));

    p_data_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_bclk) |-> $stable(aux_sdo));

endmodule

bind tdm_aux_core tdm_aux_sva u_sva (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .cfg_err(cfg_err),
    .rx_frame_done(rx_frame_done), .aux_bclk(aux_bclk),
    .aux_lrclk(aux_lrclk), .aux_sdo(aux_sdo)
);

// File: tb/tdm_aux_core_bench.sv
`timescale 1ns/1ps
module tdm_aux_core_bench;

    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic [1:0]    slot_cfg = 2'd1;
    logic          aux_req = 1'b0;
    logic [16*W-1:0] tx_data = '0;
    logic          tdm_sdo;
    logic          tdm_sdi = 1'b0;
    logic [16*W-1:0] rx_data;
    logic          rx_frame_done;
    logic          aux_bclk;
    logic          aux_lrclk;
    logic [1:0]    aux_sdo;
    logic          cfg_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [W-1:0] txw [16];
    logic [W-1:0] rxw [16];
    logic [W-1:0] prev_rx [16];
    logic [W-1:0] prev_aux [4];
    bit  have_prev = 0;
    bit  prev_aux_ok = 0;
    int  prev_ns = 0;

    always #2 clk = ~clk;

    tdm_aux_core u_tdm_aux_core (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_cfg(slot_cfg), .aux_req(aux_req),
        .tx_data(tx_data), .tdm_sdo(tdm_sdo), .tdm_sdi(tdm_sdi), .rx_data(rx_data),
        .rx_frame_done(rx_frame_done), .aux_bclk(aux_bclk), .aux_lrclk(aux_lrclk),
        .aux_sdo(aux_sdo), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int cfg, input bit aux, input int seed);
        int  ns;
        bit  aux_eff;
        bit  err_exp;
        bit  act;
        ns      = (cfg == 0) ? 4 : (cfg == 2) ? 16 : 8;
        aux_eff = aux && (cfg == 2);
        err_exp = (cfg == 3) || (aux && (cfg != 2));
        act     = aux_eff && prev_aux_ok;
        for (int s = 0; s < 16; s++) begin
            if (seed == 0) begin
                txw[s] = '1;
                rxw[s] = 24'h800001;
            end else begin
                txw[s] = W'(seed * 32'd2654435 + s * 32'd40503 + 32'h00A5C3);
                rxw[s] = W'((seed * 32'd1103515) ^ (s * 32'd77773) ^ 32'h3C5A11);
            end
            tx_data[s*W +: W] = txw[s];
        end
        fsync    = 1'b1;
        slot_cfg = 2'(cfg);
        aux_req  = aux;
        for (int p = 0; p < ns * 32; p++) begin
            int s;
            int b;
            int h;
            logic e;
            @(negedge clk);
            s = p / 32;
            b = p % 32;
            if (p == 0) begin
                fsync = 1'b0;
                check("R9 cfg_err", 32'(cfg_err), 32'(err_exp));
                if (have_prev) begin
                    check("R1 done at frame end", 32'(rx_frame_done), 32'd1);
                    for (int k = 0; k < prev_ns; k++)
                        check("R4 rx word", 32'(rx_data[k*W +: W]), 32'(prev_rx[k]));
                end
            end
            if (p == 1) check("R11 done one cycle", 32'(rx_frame_done), 32'd0);
            if (p == 5) begin
                slot_cfg = 2'(cfg) ^ 2'b01;
                aux_req  = !aux;
            end
            e = (s < 4 && s < ns && b < W) ? txw[s][W-1-b] : 1'b0;
            if (s < 4) check("R2 tx bit", 32'(tdm_sdo), 32'(e));
            else       check("R3 unused slot", 32'(tdm_sdo), 32'(e));
            if (act) begin
                h = (p >> 8) & 1;
                check("R7 aux_bclk", 32'(aux_bclk), 32'((p >> 2) & 1));
                check("R7 aux_lrclk", 32'(aux_lrclk), 32'(h));
                for (int k = 0; k < 2; k++) begin
                    int ab;
                    ab = (p >> 3) & 31;
                    e = (ab < W) ? prev_aux[2*k+h][W-1-ab] : 1'b0;
                    check("R6 aux data", 32'(aux_sdo[k]), 32'(e));
                end
            end else begin
                check("R8 aux quiet", {28'd0, aux_bclk, aux_lrclk, aux_sdo}, 32'd0);
            end
            tdm_sdi = (s < ns && b < W) ? rxw[s][W-1-b] : b[0];
            if (p == ns * 32 - 1) check("R5 cfg held", 32'(cfg_err), 32'(err_exp));
        end
        have_prev   = 1;
        prev_ns     = ns;
        prev_aux_ok = aux_eff;
        for (int s = 0; s < 16; s++) prev_rx[s] = rxw[s];
        for (int k = 0; k < 4; k++) prev_aux[k] = rxw[12+k];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R10 reset state",
                  {27'd0, tdm_sdo, rx_frame_done, aux_bclk, aux_lrclk, cfg_err}, 32'd0);
            check("R10 reset aux", 32'(aux_sdo), 32'd0);
        end
        run_frame(1, 0, 1);
        run_frame(1, 0, 0);
        run_frame(0, 0, 2);
        run_frame(2, 0, 3);
        run_frame(2, 1, 4);
        run_frame(2, 1, 0);
        run_frame(2, 1, 5);
        run_frame(1, 1, 6);
        run_frame(2, 1, 7);
        run_frame(2, 1, 8);
        run_frame(3, 0, 9);
        run_frame(0, 1, 10);
        run_frame(1, 0, 11);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule